// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a one-bit serial stream and cuts it into fixed, back-to-back frames of three bits. During the last bit of a frame, the match output rises when the frame's last two bits are "1" then "0". In the bench's notation, with the first bit written leftmost, these are the frames 010 and 110. The first bit of each frame has no effect on the result. After every third bit the machine goes back to its frame-start state whatever it saw, so a pattern that spans two frames is never reported.

The control is a four-state Mealy machine: frame start, one bit seen, two bits seen ending in 0, and two bits seen ending in 1. The match output is decoded from the current state and the live input bit, so it is valid in the same cycle as the third bit. Reset is asynchronous and active low on the pin. An internal synchronizer releases it on a clock edge, so framing starts at a known edge after reset is released.

Top module: `frame_pat_det`

## Requirements
- R1: While `rst_n` is low, `match` is 0 and the machine holds the frame-start state. After `rst_n` rises, the bit sampled at the (SYNC_STAGES+1)-th rising clock edge is the first bit of the first frame.
- R2: While the third bit of a frame is on `din`, `match` is 1 exactly when the frame's second bit was 1 and the third bit is 0 (the frames 010 and 110, first bit leftmost). It is 0 for the other six frames.
- R3: The first bit of a frame has no effect: two frames that differ only in their first bit produce the same `match` value.
- R4: Frames do not overlap. After the third bit the machine is back at frame start whatever it saw, so a "10" or "010" that spans a frame boundary does not raise `match`.
- R5: `match` is 0 while the first or the second bit of any frame is on `din`, whatever its value.
- R6: `match` is combinational from the state and `din`. During a third bit, changing `din` within the cycle changes `match` in that same cycle.
- R7: Pulling `rst_n` low in the middle of a frame forces `match` to 0 at once. After release, counting starts again with a fresh frame, as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 1 | Serial data bit, one per clock, first bit of a frame first |
| match | output | 1 | Mealy match flag, high during the third bit of a 010 or 110 frame |

## Verification
A wrong internal state shows up at the port within one frame. A frame-position error shifts the frame boundary, so `match` fires on misaligned data or misses a true pattern within at most three bits. A wrong two-bit state flips `match` on the very next third bit. The bench therefore runs every one of the eight frames back to back and also feeds streams whose patterns straddle frame boundaries. It toggles `din` within a third-bit cycle to expose a registered output, and it resets the block in mid-frame to confirm that framing starts over.

// File: rtl/frame_pat_pkg.sv
package frame_pat_pkg;

  // Four-state minimized control; binary code, two flops.
  typedef enum logic [1:0] {
    PH_START = 2'b00,  // waiting for first bit of a frame
    PH_ONE   = 2'b01,  // one bit of the frame consumed
    PH_LOW   = 2'b10,  // two bits consumed, second was 0
    PH_HIGH  = 2'b11   // two bits consumed, second was 1
  } phase_e;

endpackage

// File: rtl/frame_rst_sync.sv
module frame_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/frame_phase_fsm.sv
module frame_phase_fsm
  import frame_pat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   din,
  output phase_e phase
);

  phase_e phase_q, phase_d;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_START: phase_d = PH_ONE;
      PH_ONE:   phase_d = din ? PH_HIGH : PH_LOW;
      PH_LOW:   phase_d = PH_START;
      PH_HIGH:  phase_d = PH_START;
      default:  phase_d = PH_START;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_START;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R3: the first bit never selects a branch
  a_r3_first_bit_blind: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START) |=> (phase_q == PH_ONE));

  // R2: the second bit picks the two-bit state
  a_r2_second_bit_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ONE) |=> (phase_q == ($past(din) ? PH_HIGH : PH_LOW)));

  // R4: frame end always goes back to start
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW || phase_q == PH_HIGH) |=> (phase_q == PH_START));

endmodule

// File: rtl/frame_match_dec.sv
module frame_match_dec
  import frame_pat_pkg::*;
(
  input  phase_e phase,
  input  logic   din,
  output logic   match
);

  always_comb begin
    match = 1'b0;
    if (phase == PH_HIGH && !din) match = 1'b1;
  end

  // R5: no match on the first or second bit of a frame
  always_comb begin
    if (phase == PH_START || phase == PH_ONE)
      a_r5_quiet_early: assert (!match);
  end

endmodule

// File: rtl/frame_pat_det.sv
module frame_pat_det
  import frame_pat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic match
);

  logic   rst_int_n;
  phase_e phase;

  frame_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  frame_phase_fsm u_fsm (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (din),
    .phase(phase)
  );

  frame_match_dec u_dec (
    .phase(phase),
    .din  (din),
    .match(match)
  );

  // R4: a reported match always closes its frame
  a_r4_match_closes_frame: assert property (@(posedge clk) disable iff (!rst_int_n)
    match |=> (phase == PH_START));

  // R1/R7: held reset keeps the output low
  always @(posedge clk) begin
    if (!rst_int_n) a_r1_reset_quiet: assert (!match);
  end

endmodule

// File: tb/tb_frame_pat_det.sv
module tb_frame_pat_det;

  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic match;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model state
  int  ref_pos = 0;
  bit  ref_second = 0;

  always #10 clk = ~clk;  // 50 MHz

  frame_pat_det #(.SYNC_STAGES(STG)) dut (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .match(match)
  );

  task automatic check(input bit act, input bit exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: match=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bit, check match mid-cycle, advance the model.
  task automatic send_bit(input bit b, input string req);
    bit exp;
    @(negedge clk);
    din = b;
    #5;
    exp = (ref_pos == 2) && ref_second && !b;
    check(match, exp, req);
    if (ref_pos == 1) ref_second = b;
    ref_pos = (ref_pos == 2) ? 0 : ref_pos + 1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STG) @(posedge clk);
    ref_pos = 0;
    ref_second = 0;
  endtask

  // R1: reset state
  task automatic t_reset_state();
    rst_n = 1'b0;
    din = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      din = i[0];
      #5;
      check(match, 1'b0, "R1 reset");
    end
    release_reset();
    // first frame after release must align: 010
    send_bit(1'b0, "R1 align");
    send_bit(1'b1, "R1 align");
    send_bit(1'b0, "R1 align");
  endtask

  // R2/R5: all eight frames back to back, twice
  task automatic t_all_frames();
    for (int rep = 0; rep < 2; rep++)
      for (int f = 0; f < 8; f++) begin
        send_bit(f[2], "R5 first bit");
        send_bit(f[1], "R5 second bit");
        send_bit(f[0], "R2 third bit");
      end
  endtask

  // R3: frames differing only in first bit
  task automatic t_first_bit_ignored();
    for (int f = 0; f < 4; f++) begin
      send_bit(1'b0, "R3 lead0");
      send_bit(f[1], "R3");
      send_bit(f[0], "R3");
      send_bit(1'b1, "R3 lead1");
      send_bit(f[1], "R3");
      send_bit(f[0], "R3");
    end
  endtask

  // R4: patterns straddling boundaries
  task automatic t_misaligned();
    bit seq [12] = '{1,1,1, 1,0,1, 0,0,1, 1,0,0};
    for (int i = 0; i < 12; i++) send_bit(seq[i], "R4 straddle");
  endtask

  // R6: same-cycle response on the third bit
  task automatic t_mealy();
    send_bit(1'b1, "R6 lead");
    send_bit(1'b1, "R6 second");
    @(negedge clk);
    din = 1'b0;
    #3;
    check(match, 1'b1, "R6 din0");
    din = 1'b1;
    #3;
    check(match, 1'b0, "R6 din1");
    din = 1'b0;
    #2;
    check(match, 1'b1, "R6 din0 again");
    ref_pos = 0;
  endtask

  // R7: reset in the middle of a frame
  task automatic t_midframe_reset();
    send_bit(1'b0, "R7 lead");
    send_bit(1'b1, "R7 second");
    @(negedge clk);
    din = 1'b0;
    #2;
    check(match, 1'b1, "R7 before reset");
    rst_n = 1'b0;
    #2;
    check(match, 1'b0, "R7 async clear");
    @(negedge clk);
    #5;
    check(match, 1'b0, "R7 held");
    release_reset();
    send_bit(1'b1, "R7 fresh");
    send_bit(1'b1, "R7 fresh");
    send_bit(1'b0, "R7 fresh match");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_all_frames();
    t_first_bit_ignored();
    t_misaligned();
    t_mealy();
    t_all_frames();
    t_midframe_reset();
    t_all_frames();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule